// File: doc/BRIEF.md
# Electrically Erasable Byte Memory Mode Controller

This block is a synthesizable behavioural model of a byte-wide read-only memory that can be programmed and erased electrically. Its array depth is set by a parameter. Each cycle it decodes three active-low controls:

- a chip select,
- an output gate,
- a program strobe.

Two single-bit flags stand in for the analog levels. One says that the elevated programming supply is present. The other says that the high-voltage level is on the identifier/erase address pin. From these inputs the block picks one operating mode: standby, read, output off, program, program verify, chip erase, erase verify or identifier read.

The three-state data bus is modelled as a data word plus a drive-enable flag. Analog levels, supply currents and nanosecond timing are not modelled.

The array is updated only on a falling edge of the program strobe. One falling edge is one operation. Programming can only clear bits: the stored byte becomes the bitwise AND of the old byte and the input byte. Only a whole-array erase can set bits back to 1.

Top module: `eemem_ctrl`

## Requirements
- R1: While `ce_n` is 1, `dout_en` is 0, whatever the values of `oe_n`, `pgm_n` and the flags.
- R2: With `ce_n`=0, `oe_n`=0 and both flags 0, `dout_en` is 1 and `dout` equals the byte stored at `addr`, in the same cycle.
- R3: With `ce_n`=0 and `oe_n`=1, `dout_en` is 0.
- R4: A falling edge of `pgm_n` with `ce_n`=0, `oe_n`=1, `hv_supply`=1 and `hv_a9`=0 stores (old AND `din`) at `addr`. The new value can be read from the cycle after the edge is sampled.
- R5: Programming never changes a stored bit from 0 to 1.
- R6: A falling edge of `pgm_n` with `ce_n`=0, `oe_n`=1, `hv_supply`=1, `hv_a9`=1 and `addr[0]`=0 sets every byte to 8'hFF. The same strobe with `addr[0]`=1 changes nothing.
- R7: With `ce_n`=0, `oe_n`=0, `hv_a9`=1 and `hv_supply`=0, `dout_en` is 1. `dout` is 8'hDA when `addr[0]`=0 and 8'h01 when `addr[0]`=1.
- R8: With `hv_supply`=1, `ce_n`=0 and `oe_n`=0 (verify modes), `dout` drives the stored byte at `addr`.
- R9: A program or erase strobe while `ce_n`=1 leaves the array unchanged.
- R10: A program or erase strobe while `hv_supply`=0 leaves the array unchanged.
- R11: After synchronous reset every byte reads 8'hFF.
- R12: Only a high-to-low transition of `pgm_n` starts an operation. A `pgm_n` that is already low when the write conditions appear does not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program/erase strobe, active low |
| hv_supply | input | 1 | Elevated programming supply present |
| hv_a9 | input | 1 | High-voltage level on the identifier/erase pin |
| addr | input | ADDR_W | Byte address; bit 0 also selects the identifier byte |
| din | input | 8 | Byte to be programmed |
| dout | output | 8 | Data driven onto the bus |
| dout_en | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The assertions check on every cycle the rules that can be judged from the ports or from adjacent state:

- bus release in standby and with the output gate high,
- the fixed identifier byte,
- a strobe edge lasting one cycle,
- no write under inhibit or without the supply,
- programming never raising a bit,
- erase leaving the end bytes at all ones.

Only the bench scenarios can show the contents of the whole array across sequences. These include AND accumulation from repeated programming, erase gated by address bit 0, a strobe that is already low when the supply rises, and random mixes of reads and writes checked against a shadow array.

// File: rtl/eemem_pkg.sv
// Package: shared mode encoding and identifier constants for the
// erasable byte memory model. Assumes a byte-wide data path.
package eemem_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] ID_MAKER  = 8'hDA;
    localparam logic [BYTE_W-1:0] ID_DEVICE = 8'h01;
    localparam logic [BYTE_W-1:0] ERASED    = 8'hFF;

    typedef enum logic [2:0] {
        M_STANDBY   = 3'd0,
        M_READ      = 3'd1,
        M_OUT_OFF   = 3'd2,
        M_PROG      = 3'd3,
        M_PROG_VFY  = 3'd4,
        M_ERASE     = 3'd5,
        M_ERASE_VFY = 3'd6,
        M_IDENT     = 3'd7
    } mode_e;
endpackage

// File: rtl/eemem_strobe_edge.sv
// Strobe edge detector: flags the cycle in which the active-low
// program strobe is first seen low after being high. Assumes the
// strobe is already synchronous to clk.
module eemem_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pgm_n,
    output logic fall
);
    logic pgm_q;

    // Purpose: remember last sampled strobe level (idle high after reset).
    always_ff @(posedge clk) begin
        if (!rst_n) pgm_q <= 1'b1;
        else        pgm_q <= pgm_n;
    end

    assign fall = pgm_q & ~pgm_n;

    a_r12_one_cycle_edge: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/eemem_mode_decode.sv
// Mode decoder: maps the control pins and the two high-voltage flags
// to one operating mode, and qualifies the strobe edge into program
// or erase commands. Purely combinational.
module eemem_mode_decode
    import eemem_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  hv_supply,
    input  logic  hv_a9,
    input  logic  a0,
    input  logic  fall,
    output mode_e mode,
    output logic  do_prog,
    output logic  do_erase
);
    // Purpose: select the operating mode from pin levels.
    always_comb begin
        mode = M_STANDBY;
        if (!ce_n) begin
            if (!oe_n) begin
                if (hv_a9 && !hv_supply)
                    mode = M_IDENT;
                else if (hv_supply)
                    mode = (hv_a9 && !a0) ? M_ERASE_VFY : M_PROG_VFY;
                else
                    mode = M_READ;
            end else begin
                if (hv_supply && hv_a9)
                    mode = a0 ? M_OUT_OFF : M_ERASE;
                else if (hv_supply)
                    mode = M_PROG;
                else
                    mode = M_OUT_OFF;
            end
        end
    end

    // Purpose: turn a strobe edge into a single array command.
    always_comb begin
        do_prog  = fall && (mode == M_PROG);
        do_erase = fall && (mode == M_ERASE);
    end

    a_r9_inhibit_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !(do_prog || do_erase));
    a_r10_no_supply_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_supply |-> !(do_prog || do_erase));
    a_r6_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_prog, do_erase}));
endmodule

// File: rtl/eemem_array.sv
// Storage array: DEPTH bytes. Reset and erase fill it with ones;
// programming ANDs the input byte into one location. The read port
// is asynchronous at the current address.
module eemem_array
    import eemem_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    input  logic              prog_en,
    input  logic              erase_en,
    output logic [BYTE_W-1:0] rd_data
);
    logic [BYTE_W-1:0] mem [DEPTH];

    // Purpose: apply reset fill, whole-array erase or bit-clearing program.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_en) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else if (prog_en) begin
            mem[addr] <= mem[addr] & din;
        end
    end

    assign rd_data = mem[addr];

    a_r5_no_bit_raise: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> ((addr != $past(addr)) || ((rd_data & ~$past(rd_data)) == '0)));
    a_r6_erase_fills: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> ((mem[0] == ERASED) && (mem[DEPTH-1] == ERASED)));
endmodule

// File: rtl/eemem_out_sel.sv
// Output selector: chooses array data or an identifier byte and
// drives the bus enable according to the decoded mode.
module eemem_out_sel
    import eemem_pkg::*;
(
    input  mode_e             mode,
    input  logic              a0,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_en
);
    // Purpose: select bus data and drive enable per mode.
    always_comb begin
        dout    = rd_data;
        dout_en = 1'b0;
        unique case (mode)
            M_READ, M_PROG_VFY, M_ERASE_VFY: dout_en = 1'b1;
            M_IDENT: begin
                dout_en = 1'b1;
                dout    = a0 ? ID_DEVICE : ID_MAKER;
            end
            default: dout_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/eemem_ctrl.sv
// Top: erasable byte memory mode controller. Ties the strobe edge
// detector, mode decoder, storage array and output selector
// together. Assumes all pins are synchronous to clk.
module eemem_ctrl
    import eemem_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              hv_supply,
    input  logic              hv_a9,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);
    logic              fall;
    logic              do_prog;
    logic              do_erase;
    mode_e             mode;
    logic [BYTE_W-1:0] rd_data;

    eemem_strobe_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pgm_n (pgm_n),
        .fall  (fall)
    );

    eemem_mode_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .hv_supply (hv_supply),
        .hv_a9     (hv_a9),
        .a0        (addr[0]),
        .fall      (fall),
        .mode      (mode),
        .do_prog   (do_prog),
        .do_erase  (do_erase)
    );

    eemem_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .din      (din),
        .prog_en  (do_prog),
        .erase_en (do_erase),
        .rd_data  (rd_data)
    );

    eemem_out_sel u_out (
        .mode    (mode),
        .a0      (addr[0]),
        .rd_data (rd_data),
        .dout    (dout),
        .dout_en (dout_en)
    );

    a_r1_standby_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dout_en);
    a_r3_gate_off_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n) |-> !dout_en);
    a_r7_ident_maker: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && hv_a9 && !hv_supply && !addr[0]) |-> (dout_en && dout == 8'hDA));
endmodule

// File: tb/eemem_ctrl_bench.sv
`timescale 1ns/1ps
module eemem_ctrl_bench;
    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
    logic          hv_supply = 1'b0, hv_a9 = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] shadow [DEPTH];

    always #2.5 clk = ~clk;

    eemem_ctrl #(.ADDR_W(AW)) u_eemem_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .hv_supply(hv_supply), .hv_a9(hv_a9), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    // Expected bus enable from the requirements.
    function automatic logic exp_en(logic c, logic o);
        return !c && !o;
    endfunction

    // Expected bus data when driven.
    function automatic logic [7:0] exp_data(logic s, logic a9, logic [AW-1:0] a);
        if (a9 && !s) return a[0] ? 8'h01 : 8'hDA;
        return shadow[a];
    endfunction

    // Apply a strobe's effect to the shadow array.
    task automatic model_strobe(logic c, logic o, logic s, logic a9,
                                logic [AW-1:0] a, logic [7:0] d);
        if (!c && o && s) begin
            if (a9) begin
                if (!a[0]) for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
            end else begin
                shadow[a] = shadow[a] & d;
            end
        end
    endtask

    task automatic probe(logic c, logic o, logic s, logic a9,
                         logic [AW-1:0] a, string req);
        logic       e;
        logic [7:0] x;
        @(negedge clk);
        ce_n = c; oe_n = o; hv_supply = s; hv_a9 = a9; addr = a;
        #1;
        e = exp_en(c, o);
        x = exp_data(s, a9, a);
        checks++;
        if (dout_en !== e || (e && dout !== x)) begin
            failures++;
            $display("FAIL %s: addr=%0h en=%b data=%h expected en=%b data=%h",
                     req, a, dout_en, dout, e, x);
        end
    endtask

    task automatic strobe(logic c, logic o, logic s, logic a9,
                          logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        ce_n = c; oe_n = o; hv_supply = s; hv_a9 = a9; addr = a; din = d; pgm_n = 1'b1;
        @(negedge clk);
        pgm_n = 1'b0;
        @(negedge clk);
        pgm_n = 1'b1;
        model_strobe(c, o, s, a9, a, d);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int sd;
        sd = $urandom(32'h5EED_0042);
        for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset fill, R1 standby
        probe(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R11 reset");
        probe(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, "R11 reset top");
        probe(1'b1, 1'b0, 1'b0, 1'b0, 8'h10, "R1 standby oe low");
        probe(1'b1, 1'b0, 1'b1, 1'b1, 8'h10, "R1 standby hv flags");
        // R4 program, R5 AND accumulation
        strobe(1'b0, 1'b1, 1'b1, 1'b0, 8'h05, 8'h3C);
        probe(1'b0, 1'b0, 1'b0, 1'b0, 8'h05, "R4 program");
        strobe(1'b0, 1'b1, 1'b1, 1'b0, 8'h05, 8'hF3);
        probe(1'b0, 1'b0, 1'b0, 1'b0, 8'h05, "R5 no bit set");
        probe(1'b0, 1'b0, 1'b0, 1'b0, 8'h04, "R2 neighbour untouched");
        // R3 output off
        probe(1'b0, 1'b1, 1'b0, 1'b0, 8'h05, "R3 output off");
        probe(1'b0, 1'b1, 1'b1, 1'b0, 8'h05, "R3 output off supply");
        // R7 identifier
        probe(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R7 ident maker");
        probe(1'b0, 1'b0, 1'b0, 1'b1, 8'h01, "R7 ident device");
        // R8 verify reads
        probe(1'b0, 1'b0, 1'b1, 1'b0, 8'h05, "R8 program verify");
        probe(1'b0, 1'b0, 1'b1, 1'b1, 8'h04, "R8 erase verify");
        // R9 inhibit
        strobe(1'b1, 1'b1, 1'b1, 1'b0, 8'h06, 8'h00);
        probe(1'b0, 1'b0, 1'b0, 1'b0, 8'h06, "R9 inhibit program");
        strobe(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF);
        probe(1'b0, 1'b0, 1'b0, 1'b0, 8'h05, "R9 inhibit erase");
        // R10 no supply
        strobe(1'b0, 1'b1, 1'b0, 1'b0, 8'h07, 8'h00);
        probe(1'b0, 1'b0, 1'b0, 1'b0, 8'h07, "R10 no supply program");
        strobe(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'hFF);
        probe(1'b0, 1'b0, 1'b0, 1'b0, 8'h05, "R10 no supply erase");
        // R12 strobe already low
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; hv_supply = 1'b0; hv_a9 = 1'b0; addr = 8'h09; din = 8'h00;
        pgm_n = 1'b0;
        repeat (2) @(negedge clk);
        hv_supply = 1'b1;
        repeat (2) @(negedge clk);
        hv_supply = 1'b0; pgm_n = 1'b1;
        probe(1'b0, 1'b0, 1'b0, 1'b0, 8'h09, "R12 level not edge");
        // R6 erase gated by addr[0], then erase
        strobe(1'b0, 1'b1, 1'b1, 1'b0, 8'hFE, 8'h11);
        strobe(1'b0, 1'b1, 1'b1, 1'b1, 8'h01, 8'hFF);
        probe(1'b0, 1'b0, 1'b0, 1'b0, 8'h05, "R6 erase needs a0 low");
        strobe(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF);
        probe(1'b0, 1'b0, 1'b0, 1'b0, 8'h05, "R6 erase low byte");
        probe(1'b0, 1'b0, 1'b0, 1'b0, 8'hFE, "R6 erase high byte");

        // Random mix of strobes and reads (R2 R4 R5 R8 R9 R10)
        for (int n = 0; n < 400; n++) begin
            logic          c, o, s, a9;
            logic [AW-1:0] a;
            c  = ($urandom % 6) == 0;
            o  = ($urandom % 5) != 0;
            s  = ($urandom % 4) != 0;
            a9 = ($urandom % 16) == 0;
            a  = AW'($urandom % 16);
            strobe(c, o, s, a9, a, 8'($urandom));
            probe(($urandom % 8) == 0, ($urandom % 6) == 0, 1'($urandom),
                  ($urandom % 8) == 0, AW'($urandom % 16), "R2 random readback");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule